// File: doc/BRIEF.md
# Touch Sample Batch Filter

This block turns a stream of packed resistive-touch samples into one clean touch report per batch. A batch-start trigger makes it pull up to four sample words from an upstream sample FIFO. Each coordinate is inverted so that both axes count the other way. The position is the average of the two middle samples of the batch. The block then checks whether the pen was still down in the final sample, and issues a single report strobe that carries either a position with touch asserted or a release.

A batch can end early when the FIFO runs dry. If the FIFO has overrun by the time a batch starts, the block drains and discards everything queued, and that batch produces no report. A `busy` output covers the whole batch. Triggers that arrive while a batch is already running are dropped.

Top module: `touch_batch_filter`

## Requirements
- R1: A start trigger seen while idle begins a batch; `busy_o` is high from the cycle after the trigger until the report strobe cycle (or the end of a drain) inclusive, and low otherwise.
- R2: `smp_ready_o` is high only during a batch and only while `fifo_empty_i` is low; it is low while idle even if samples are waiting, and a batch accepts at most four samples.
- R3: Each accepted word is converted per axis as 1023 minus the raw 10-bit field, with X taken from bits 25:16 and Y from bits 9:0.
- R4: The reported X and Y are each the truncating average (11-bit sum shifted right by one) of the converted second and third samples of the batch.
- R5: `rpt_touch_o` is 1 only when exactly four samples were accepted and bit 31 (pen-up flag, 1 = pen up) of the fourth is 0; the flags of earlier samples have no effect.
- R6: If the FIFO reports empty before four samples are accepted, including at batch start, the batch ends and a release report (`rpt_touch_o` = 0) is issued.
- R7: A release report drives `rpt_x_o` and `rpt_y_o` to zero.
- R8: If `fifo_overrun_i` is high when a batch starts, samples are accepted and discarded until `fifo_empty_i` is high, no report is issued, and the block returns to idle.
- R9: Every batch that is not an overrun batch produces exactly one report strobe, `rpt_valid_o`, which is high for a single cycle.
- R10: A start trigger that arrives while `busy_o` is high is ignored and produces no additional batch or report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Batch-start trigger |
| fifo_empty_i | input | 1 | Upstream FIFO holds no sample |
| fifo_overrun_i | input | 1 | Upstream FIFO has overrun |
| smp_valid_i | input | 1 | Sample word present |
| smp_data_i | input | 32 | Packed sample word |
| smp_ready_o | output | 1 | Sample accepted this cycle when valid |
| busy_o | output | 1 | Batch in progress |
| rpt_valid_o | output | 1 | Report strobe, one cycle |
| rpt_x_o | output | 10 | Reported X position |
| rpt_y_o | output | 10 | Reported Y position |
| rpt_touch_o | output | 1 | 1 = position valid with touch, 0 = release |

## Verification
The bench builds the filter with its defaults: a batch of four, 10-bit coordinates, and X, Y and pen-up fields at bits 16, 0 and 31. With these values the middle samples are the second and third. Raw fields of 0 and 1023 exercise the full width of the inverted sum, and an odd sum exercises the truncation. Because the bench's FIFO model can hold more than four words, some batches leave samples behind for the next batch to consume. The bench can also hold the stream stalled while it issues extra triggers.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DRAIN   = 2'd2,
        ST_REPORT  = 2'd3
    } tsf_state_e;

    localparam int unsigned AXES = 2;

    // index into per-axis arrays
    localparam int unsigned AX_X = 0;
    localparam int unsigned AX_Y = 1;

    function automatic int unsigned mid_lo(input int unsigned batch);
        return batch / 2 - 1;
    endfunction

    function automatic int unsigned mid_hi(input int unsigned batch);
        return batch / 2;
    endfunction

endpackage

// File: rtl/tsf_unpack.sv
module tsf_unpack #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned COORD_W = 10,
    parameter int unsigned X_LSB   = 16,
    parameter int unsigned Y_LSB   = 0,
    parameter int unsigned PEN_BIT = 31
) (
    input  logic [WORD_W-1:0]  word_i,
    output logic [COORD_W-1:0] x_o,
    output logic [COORD_W-1:0] y_o,
    output logic               pen_up_o
);
    localparam logic [COORD_W-1:0] FULL = '1;

    logic unused_word;
    assign unused_word = ^word_i;

    // inverted axes
    assign x_o      = FULL - word_i[X_LSB +: COORD_W];
    assign y_o      = FULL - word_i[Y_LSB +: COORD_W];
    assign pen_up_o = word_i[PEN_BIT];

endmodule

// File: rtl/tsf_avg.sv
module tsf_avg #(
    parameter int unsigned COORD_W = 10
) (
    input  logic [COORD_W-1:0] a_i,
    input  logic [COORD_W-1:0] b_i,
    output logic [COORD_W-1:0] avg_o
);
    localparam int unsigned SUM_W = COORD_W + 1;

    logic [SUM_W-1:0] sum;
    logic             unused_lsb;

    assign sum        = {1'b0, a_i} + {1'b0, b_i};
    assign avg_o      = sum[SUM_W-1:1];
    assign unused_lsb = sum[0];

endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
    import tsf_pkg::*;
#(
    parameter int unsigned BATCH = 4,
    parameter int unsigned CNT_W = $clog2(BATCH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             overrun_i,
    input  logic             empty_i,
    input  logic             valid_i,
    output logic             ready_o,
    output logic             pop_o,
    output logic             collect_o,
    output logic             busy_o,
    output logic             report_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BATCH - 1);

    tsf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        ready_o = 1'b0;
        if (!empty_i) begin
            if (state_q == ST_DRAIN) ready_o = 1'b1;
            if (state_q == ST_COLLECT && cnt_q < CNT_W'(BATCH)) ready_o = 1'b1;
        end
    end

    assign pop_o     = ready_o && valid_i;
    assign collect_o = (state_q == ST_COLLECT);
    assign busy_o    = (state_q != ST_IDLE);
    assign report_o  = (state_q == ST_REPORT);
    assign count_o   = cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = overrun_i ? ST_DRAIN : ST_COLLECT;
            ST_COLLECT: begin
                if (pop_o && cnt_q == LAST) state_d = ST_REPORT;
                else if (empty_i)          state_d = ST_REPORT;
            end
            ST_DRAIN:   if (empty_i) state_d = ST_IDLE;
            ST_REPORT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) cnt_q <= '0;
            else if (pop_o && state_q == ST_COLLECT) cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    ready_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !empty_i);

    // R2
    batch_limit_chk: assert property (@(posedge clk) disable iff (rst)
        count_o <= CNT_W'(BATCH));

    // R8
    drain_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && empty_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/touch_batch_filter.sv
module touch_batch_filter
    import tsf_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned COORD_W = 10,
    parameter int unsigned X_LSB   = 16,
    parameter int unsigned Y_LSB   = 0,
    parameter int unsigned PEN_BIT = 31,
    parameter int unsigned BATCH   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               fifo_empty_i,
    input  logic               fifo_overrun_i,
    input  logic               smp_valid_i,
    input  logic [WORD_W-1:0]  smp_data_i,
    output logic               smp_ready_o,
    output logic               busy_o,
    output logic               rpt_valid_o,
    output logic [COORD_W-1:0] rpt_x_o,
    output logic [COORD_W-1:0] rpt_y_o,
    output logic               rpt_touch_o
);
    localparam int unsigned CNT_W  = $clog2(BATCH + 1);
    localparam int unsigned IDX_LO = mid_lo(BATCH);
    localparam int unsigned IDX_HI = mid_hi(BATCH);
    localparam int unsigned NSLOT  = 2;

    logic             pop, collect, report;
    logic [CNT_W-1:0] count;

    tsf_ctrl #(.BATCH(BATCH), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .overrun_i (fifo_overrun_i),
        .empty_i   (fifo_empty_i),
        .valid_i   (smp_valid_i),
        .ready_o   (smp_ready_o),
        .pop_o     (pop),
        .collect_o (collect),
        .busy_o    (busy_o),
        .report_o  (report),
        .count_o   (count)
    );

    logic [COORD_W-1:0] cur [AXES];
    logic               cur_pen;

    tsf_unpack #(
        .WORD_W (WORD_W), .COORD_W(COORD_W),
        .X_LSB  (X_LSB),  .Y_LSB  (Y_LSB), .PEN_BIT(PEN_BIT)
    ) u_unpack (
        .word_i   (smp_data_i),
        .x_o      (cur[AX_X]),
        .y_o      (cur[AX_Y]),
        .pen_up_o (cur_pen)
    );

    // two capture slots (middle samples), each with both axes
    logic [COORD_W-1:0] slot_q [NSLOT][AXES];
    logic [COORD_W-1:0] avg    [AXES];
    logic               last_pen_q;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [CNT_W-1:0] SLOT_IDX = CNT_W'((s == 0) ? IDX_LO : IDX_HI);
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[s][AX_X] <= '0;
                slot_q[s][AX_Y] <= '0;
            end else if (pop && collect && count == SLOT_IDX) begin
                slot_q[s][AX_X] <= cur[AX_X];
                slot_q[s][AX_Y] <= cur[AX_Y];
            end
        end
    end

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        tsf_avg #(.COORD_W(COORD_W)) u_avg (
            .a_i   (slot_q[0][a]),
            .b_i   (slot_q[1][a]),
            .avg_o (avg[a])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                 last_pen_q <= 1'b1;
        else if (pop && collect) last_pen_q <= cur_pen;
    end

    logic touch;
    assign touch       = (count == CNT_W'(BATCH)) && !last_pen_q;
    assign rpt_valid_o = report;
    assign rpt_touch_o = report && touch;
    assign rpt_x_o     = rpt_touch_o ? avg[AX_X] : '0;
    assign rpt_y_o     = rpt_touch_o ? avg[AX_Y] : '0;

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        rpt_valid_o |=> !rpt_valid_o);

    // R7
    release_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid_o && !rpt_touch_o) |-> (rpt_x_o == '0 && rpt_y_o == '0));

    // R2
    ready_in_batch_chk: assert property (@(posedge clk) disable iff (rst)
        smp_ready_o |-> busy_o);

    // R1
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> ($past(rpt_valid_o) || $past(fifo_empty_i)));

    // R5
    touch_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rpt_touch_o |-> rpt_valid_o);

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !rpt_valid_o && !$past(rst) && start_i) |=> busy_o);

endmodule

// File: tb/test_touch_batch_filter.sv
module test_touch_batch_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        fifo_empty_i = 1'b1;
    logic        fifo_overrun_i = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [31:0] smp_data_i = '0;
    logic        smp_ready_o, busy_o, rpt_valid_o, rpt_touch_o;
    logic [9:0]  rpt_x_o, rpt_y_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    touch_batch_filter i_touch_batch_filter (
        .clk(clk), .rst(rst), .start_i(start_i),
        .fifo_empty_i(fifo_empty_i), .fifo_overrun_i(fifo_overrun_i),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
        .smp_ready_o(smp_ready_o), .busy_o(busy_o),
        .rpt_valid_o(rpt_valid_o), .rpt_x_o(rpt_x_o),
        .rpt_y_o(rpt_y_o), .rpt_touch_o(rpt_touch_o)
    );

    typedef struct { logic [9:0] x; logic [9:0] y; logic t; string tag; } rpt_t;

    logic [31:0] fifo_q [$];
    rpt_t        exp_q  [$];
    int          n_chk = 0, n_fail = 0, n_rpt = 0, n_exp = 0;
    logic        stall = 1'b0;
    logic        take  = 1'b0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] mk(input int rx, input int ry, input logic pen);
        return {pen, 5'd0, rx[9:0], 6'd0, ry[9:0]};
    endfunction

    task automatic refresh();
        fifo_empty_i = (fifo_q.size() == 0);
        smp_valid_i  = (fifo_q.size() != 0) && !stall;
        smp_data_i   = (fifo_q.size() != 0) ? fifo_q[0] : '0;
    endtask

    // FIFO model: decide at negedge+1, pop just after posedge
    always @(negedge clk) begin
        #1;
        refresh();
        take = smp_ready_o && smp_valid_i;
    end
    always @(posedge clk) begin
        #1;
        if (take) void'(fifo_q.pop_front());
        take = 1'b0;
        refresh();
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rpt_valid_o) begin
            n_rpt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected report", 1, 0);
            end else begin
                rpt_t e;
                e = exp_q.pop_front();
                chk(rpt_touch_o == e.t, {e.tag, " touch"}, int'(rpt_touch_o), int'(e.t));
                chk(rpt_x_o == e.x, {e.tag, " X"}, int'(rpt_x_o), int'(e.x));
                chk(rpt_y_o == e.y, {e.tag, " Y"}, int'(rpt_y_o), int'(e.y));
            end
        end
    end

    // expected report from current FIFO content (R3 R4 R5 R6 R7)
    task automatic push_expect(input string tag);
        rpt_t e;
        int n;
        n = (fifo_q.size() < 4) ? fifo_q.size() : 4;
        e.tag = tag;
        if (n == 4 && !fifo_q[3][31]) begin
            int x1, x2, y1, y2;
            x1 = 1023 - int'(fifo_q[1][25:16]);
            x2 = 1023 - int'(fifo_q[2][25:16]);
            y1 = 1023 - int'(fifo_q[1][9:0]);
            y2 = 1023 - int'(fifo_q[2][9:0]);
            e.t = 1'b1;
            e.x = 10'((x1 + x2) / 2);
            e.y = 10'((y1 + y2) / 2);
        end else begin
            e.t = 1'b0; e.x = '0; e.y = '0;
        end
        exp_q.push_back(e);
        n_exp++;
    endtask

    task automatic run_batch(input string tag, input logic ovr);
        if (!ovr) push_expect(tag);
        fifo_overrun_i = ovr;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
        while (busy_o) @(negedge clk);
        fifo_overrun_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && rpt_valid_o == 0 && smp_ready_o == 0, "reset state", int'(busy_o), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2: idle does not accept waiting samples
        fifo_q.push_back(mk(100, 200, 0));
        repeat (2) @(negedge clk);
        chk(smp_ready_o == 0, "R2 ready while idle", int'(smp_ready_o), 0);
        fifo_q.push_back(mk(300, 400, 0));
        fifo_q.push_back(mk(500, 600, 0));
        fifo_q.push_back(mk(700, 800, 0));
        run_batch("R3 R4 basic", 1'b0);
        chk(fifo_q.size() == 0, "R2 four popped", fifo_q.size(), 0);

        // extremes and truncation: conv x 1023,1022 -> 1022 ; y 0,0 -> 0
        fifo_q.push_back(mk(5, 5, 1));
        fifo_q.push_back(mk(0, 1023, 0));
        fifo_q.push_back(mk(1, 1023, 0));
        fifo_q.push_back(mk(9, 9, 0));
        run_batch("R4 extremes", 1'b0);

        // R7 pen up in fourth sample
        fifo_q.push_back(mk(10, 20, 0));
        fifo_q.push_back(mk(30, 40, 0));
        fifo_q.push_back(mk(50, 60, 0));
        fifo_q.push_back(mk(70, 80, 1));
        run_batch("R7 pen up last", 1'b0);

        // R5 pen up earlier only -> still touch
        fifo_q.push_back(mk(11, 22, 1));
        fifo_q.push_back(mk(33, 44, 1));
        fifo_q.push_back(mk(55, 66, 1));
        fifo_q.push_back(mk(77, 88, 0));
        run_batch("R5 early pen up", 1'b0);

        // R6 three samples
        fifo_q.push_back(mk(1, 2, 0));
        fifo_q.push_back(mk(3, 4, 0));
        fifo_q.push_back(mk(5, 6, 0));
        run_batch("R6 short batch", 1'b0);
        chk(fifo_q.size() == 0, "R6 short drained", fifo_q.size(), 0);

        // R6 empty at start
        run_batch("R6 empty start", 1'b0);

        // six samples -> two batches, second short
        for (int i = 0; i < 6; i++) fifo_q.push_back(mk(100 + 37*i, 900 - 41*i, 0));
        run_batch("R4 six first", 1'b0);
        chk(fifo_q.size() == 2, "R2 limit four", fifo_q.size(), 2);
        run_batch("R6 six second", 1'b0);

        // R8 overrun drain
        for (int i = 0; i < 5; i++) fifo_q.push_back(mk(i, i, 0));
        run_batch("R8 overrun", 1'b1);
        chk(fifo_q.size() == 0, "R8 drained all", fifo_q.size(), 0);
        chk(n_rpt == n_exp, "R8 no report", n_rpt, n_exp);

        // R10 retrigger while stalled
        stall = 1'b1;
        for (int i = 0; i < 4; i++) fifo_q.push_back(mk(200 + i, 300 + 3*i, 0));
        push_expect("R10 retrigger");
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (3) begin
            @(negedge clk); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        chk(busy_o == 1 && fifo_q.size() == 4, "R10 still collecting", int'(busy_o), 1);
        stall = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(busy_o == 0, "R10 no extra batch", int'(busy_o), 0);

        chk(exp_q.size() == 0, "R9 all reports seen", exp_q.size(), 0);
        chk(n_rpt == n_exp, "R9 report count", n_rpt, n_exp);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule